// File: doc/BRIEF.md
# Indirect-Access Host Bridge with Interrupt Status

This block connects a narrow 8-bit host I/O port to two peripheral controllers: a signalling-channel controller (called D here) and a two-channel bearer controller (called B here). The host sees eight byte-wide ports. It writes an internal address into a latch, then reads or writes through a data port. The bridge turns each data-port access into a one-cycle strobe towards whichever peripheral owns the latched address, and it carries the returned byte back to the host.

The bridge also holds a control/status byte and an auxiliary control byte. These drive peripheral reset, a small interval timer, the host interrupt enable, two LED outputs and the line-interface enable. It exposes two constant identification bytes. It merges the timer and both peripheral interrupt levels into one host interrupt, and it reports each source in the status byte as an active-low bit.

Top module: `hostbr_top`

## Requirements
- R1: After the synchronous reset, every strobe, `per_rst`, `host_irq`, `led`, `line_en`, `host_rvalid` and `host_rdata` is zero, and all internal registers are clear.
- R2: A write to port 2 loads the address latch. Port 2 reads back the latch. The latch is never incremented, so repeated data-port accesses all reach the same internal address.
- R3: Latched addresses map as follows. 0x00–0x1F is the D FIFO and 0x20–0x3F the D registers. 0x40–0x7F is unmapped. For the B controller, 0x80–0x9F and 0xC0–0xDF are the FIFOs and 0xA0–0xBF and 0xE0–0xFF are the registers. Bit 6 of a B address gives `bch_chan`. `per_addr` carries address bits 5:0. At most one strobe is high in any cycle.
- R4: A data-port (port 3) write raises the write strobe of the selected peripheral for one cycle, on the cycle after the host write, with `per_wdata` equal to the host byte. An unmapped address gives no strobe.
- R5: A data-port read raises the selected read strobe for one cycle, on the cycle after the host read. `host_rvalid` is high two cycles after the host read, with `host_rdata` holding the peripheral's byte, or 0x00 when the address is unmapped. Every port read has this two-cycle latency.
- R6: A port 4 read returns the following. Bit 7 is the stored test bit. Bit 6 is low while the B interrupt is pending, bit 5 is low while the D interrupt is pending, and bit 4 is low while the timer flag is set. Bits 3:0 read 0.
- R7: Control byte bit 0, written through port 4, drives `per_rst` as a level from the next cycle until it is rewritten.
- R8: The timer counts down from `TMR_RELOAD` and reloads. It sets its flag at every terminal count, once per `TMR_RELOAD`+1 running cycles. While bit 2 of the control byte is 1, the count is reloaded and the flag is cleared. While bit 1 is 1, the count and the flag are frozen.
- R9: `host_irq` equals, one cycle later, control bit 3 AND (D interrupt OR B interrupt OR timer flag). It falls once every source is clear.
- R10: Port 5 stores a byte and reads it back. Bit 4 drives `led[0]` and bit 5 drives `led[1]`. `line_en` is high only when bits 7 and 6 are both 1.
- R11: Ports 6 and 7 read `MODEL_ID` and `VERSION_ID`, and writes to them have no effect. Ports 0 and 1 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host port offset |
| host_rd | input | 1 | Host read request, one cycle |
| host_wr | input | 1 | Host write request, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | host_rdata valid |
| host_irq | output | 1 | Combined host interrupt |
| dch_irq | input | 1 | D controller interrupt level |
| bch_irq | input | 1 | B controller interrupt level |
| per_rst | output | 1 | Peripheral reset level |
| per_addr | output | 6 | Address within the peripheral window |
| bch_chan | output | 1 | B channel select |
| per_wdata | output | 8 | Write byte to peripherals |
| dch_rd | output | 1 | D read strobe |
| dch_wr | output | 1 | D write strobe |
| dch_rdata | input | 8 | D read byte, valid during dch_rd |
| bch_rd | output | 1 | B read strobe |
| bch_wr | output | 1 | B write strobe |
| bch_rdata | input | 8 | B read byte, valid during bch_rd |
| led | output | 2 | LED drive |
| line_en | output | 1 | Line interface enable |

## Verification
The properties assume the following about the inputs. The host never raises `host_rd` and `host_wr` in the same cycle. Both stay low while reset is applied. A peripheral returns its byte combinationally during its own read strobe. The stimulus drives every host request for exactly one cycle at the falling clock edge, and never overlaps a read with a write. It changes the interrupt levels only between accesses. The peripheral models answer with a byte built from the strobe address and channel, so any routing error shows up in the returned data.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = ADDR_W - 2;
  localparam int PORT_W = 3;

  localparam logic [PORT_W-1:0] P_LATCH = 3'd2;
  localparam logic [PORT_W-1:0] P_DATA  = 3'd3;
  localparam logic [PORT_W-1:0] P_CS0   = 3'd4;
  localparam logic [PORT_W-1:0] P_CTL1  = 3'd5;
  localparam logic [PORT_W-1:0] P_MODEL = 3'd6;
  localparam logic [PORT_W-1:0] P_VER   = 3'd7;

  // control byte 0 bit positions
  localparam int C0_PRST = 0;
  localparam int C0_TDIS = 1;
  localparam int C0_TCLR = 2;
  localparam int C0_IEN  = 3;
  localparam int C0_TEST = 7;
  // control byte 1 bit positions
  localparam int C1_LED0 = 4;
  localparam int C1_LED1 = 5;
  localparam int C1_LN0  = 6;
  localparam int C1_LN1  = 7;

  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_D = 2'd1, TGT_B = 2'd2} tgt_e;

  typedef struct packed {
    tgt_e             tgt;
    logic             chan;
    logic [OFF_W-1:0] off;
  } sel_t;
endpackage

// File: rtl/hostbr_decode.sv
module hostbr_decode
  import hostbr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  always_comb begin
    sel.off  = addr[OFF_W-1:0];
    sel.chan = 1'b0;
    if (addr[ADDR_W-1]) begin
      sel.tgt  = TGT_B;
      sel.chan = addr[ADDR_W-2];
    end else if (!addr[ADDR_W-2]) begin
      sel.tgt = TGT_D;
    end else begin
      sel.tgt = TGT_NONE;
    end
  end
endmodule

// File: rtl/hostbr_timer.sv
module hostbr_timer #(
  parameter int CNT_W  = 16,
  parameter int RELOAD = 99
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic clear,
  output logic flag
);
  localparam logic [CNT_W-1:0] RLD = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RLD;
      flag  <= 1'b0;
    end else if (clear) begin
      cnt_q <= RLD;
      flag  <= 1'b0;
    end else if (!hold) begin
      if (cnt_q == '0) begin
        cnt_q <= RLD;
        flag  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hostbr_irq.sv
module hostbr_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [NSRC-1:0] src,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & (|src);
  end
endmodule

// File: rtl/hostbr_top.sv
module hostbr_top
  import hostbr_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  MODEL_ID   = 8'h05,
  parameter logic [7:0]  VERSION_ID = 8'h02,
  parameter int          TMR_W      = 16,
  parameter int          TMR_RELOAD = 99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_irq,
  input  logic              dch_irq,
  input  logic              bch_irq,
  output logic              per_rst,
  output logic [OFF_W-1:0]  per_addr,
  output logic              bch_chan,
  output logic [DATA_W-1:0] per_wdata,
  output logic              dch_rd,
  output logic              dch_wr,
  input  logic [DATA_W-1:0] dch_rdata,
  output logic              bch_rd,
  output logic              bch_wr,
  input  logic [DATA_W-1:0] bch_rdata,
  output logic [1:0]        led,
  output logic              line_en
);
  localparam int NSRC = 3;

  logic [ADDR_W-1:0] latch_q;
  logic [DATA_W-1:0] c0_q, c1_q;
  sel_t              sel;

  // read pipeline stage 1
  logic              rv1_q;
  logic [PORT_W-1:0] rport1_q;
  tgt_e              rtgt1_q;
  logic [DATA_W-1:0] rd_mux;

  logic tmr_pend, tmr_clr, tmr_hold, irq_en;

  assign tmr_clr  = c0_q[C0_TCLR];
  assign tmr_hold = c0_q[C0_TDIS];
  assign irq_en   = c0_q[C0_IEN];
  assign per_rst  = c0_q[C0_PRST];
  assign led      = {c1_q[C1_LED1], c1_q[C1_LED0]};
  assign line_en  = c1_q[C1_LN1] & c1_q[C1_LN0];

  hostbr_decode u_dec (.addr(latch_q), .sel(sel));

  hostbr_timer #(.CNT_W(TMR_W), .RELOAD(TMR_RELOAD)) u_tmr (
    .clk(clk), .rst(rst), .hold(tmr_hold), .clear(tmr_clr), .flag(tmr_pend)
  );

  hostbr_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .en(irq_en),
    .src({bch_irq, dch_irq, tmr_pend}), .irq(host_irq)
  );

  // host writes, strobe generation, read stage 1
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      c0_q      <= '0;
      c1_q      <= '0;
      per_addr  <= '0;
      bch_chan  <= 1'b0;
      per_wdata <= '0;
      dch_rd    <= 1'b0;
      dch_wr    <= 1'b0;
      bch_rd    <= 1'b0;
      bch_wr    <= 1'b0;
      rv1_q     <= 1'b0;
      rport1_q  <= '0;
      rtgt1_q   <= TGT_NONE;
    end else begin
      dch_rd <= 1'b0;
      dch_wr <= 1'b0;
      bch_rd <= 1'b0;
      bch_wr <= 1'b0;
      rv1_q  <= host_rd;
      if (host_wr) begin
        unique case (host_addr)
          P_LATCH: latch_q <= host_wdata;
          P_CS0:   c0_q    <= host_wdata;
          P_CTL1:  c1_q    <= host_wdata;
          P_DATA: begin
            per_addr  <= sel.off;
            bch_chan  <= sel.chan;
            per_wdata <= host_wdata;
            dch_wr    <= (sel.tgt == TGT_D);
            bch_wr    <= (sel.tgt == TGT_B);
          end
          default: ;
        endcase
      end
      if (host_rd) begin
        rport1_q <= host_addr;
        rtgt1_q  <= sel.tgt;
        if (host_addr == P_DATA) begin
          per_addr <= sel.off;
          bch_chan <= sel.chan;
          dch_rd   <= (sel.tgt == TGT_D);
          bch_rd   <= (sel.tgt == TGT_B);
        end
      end
    end
  end

  // read stage 2 select
  always_comb begin
    rd_mux = '0;
    unique case (rport1_q)
      P_LATCH: rd_mux = latch_q;
      P_DATA: begin
        if (rtgt1_q == TGT_D)      rd_mux = dch_rdata;
        else if (rtgt1_q == TGT_B) rd_mux = bch_rdata;
      end
      P_CS0:   rd_mux = {c0_q[C0_TEST], ~bch_irq, ~dch_irq, ~tmr_pend, 4'b0000};
      P_CTL1:  rd_mux = c1_q;
      P_MODEL: rd_mux = MODEL_ID;
      P_VER:   rd_mux = VERSION_ID;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rv1_q;
      if (rv1_q) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/hostbr_chk.sv
module hostbr_chk
  import hostbr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PORT_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_rvalid,
  input logic              host_irq,
  input logic              dch_irq,
  input logic              bch_irq,
  input logic              tmr_pend,
  input logic              tmr_clr,
  input logic              irq_en,
  input logic              per_rst,
  input logic              dch_rd,
  input logic              dch_wr,
  input logic              bch_rd,
  input logic              bch_wr
);
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dch_rd, dch_wr, bch_rd, bch_wr}));

  assert_wr_origin_R4: assert property (@(posedge clk) disable iff (rst)
    (dch_wr || bch_wr) |-> $past(host_wr && host_addr == P_DATA));

  assert_rd_origin_R5: assert property (@(posedge clk) disable iff (rst)
    (dch_rd || bch_rd) |-> $past(host_rd && host_addr == P_DATA));

  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> ##1 host_rvalid);

  assert_rst_level_R7: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == P_CS0) |=> $stable(per_rst));

  assert_tmr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> !tmr_pend);

  assert_irq_merge_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> host_irq == $past(irq_en && (dch_irq || bch_irq || tmr_pend)));
endmodule

bind hostbr_top hostbr_chk u_chk (.*);

// File: tb/sim_hostbr_top.sv
module sim_hostbr_top;
  localparam int RELOAD = 99;
  localparam logic [7:0] MID = 8'h05;
  localparam logic [7:0] VID = 8'h02;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid, host_irq;
  logic       dch_irq = 1'b0, bch_irq = 1'b0;
  logic       per_rst, bch_chan, dch_rd, dch_wr, bch_rd, bch_wr, line_en;
  logic [5:0] per_addr;
  logic [7:0] per_wdata, dch_rdata, bch_rdata;
  logic [1:0] led;

  // peripheral stubs: byte depends on address and channel
  assign dch_rdata = {2'b01, per_addr};
  assign bch_rdata = {1'b1, bch_chan, per_addr};

  hostbr_top #(.MODEL_ID(MID), .VERSION_ID(VID), .TMR_RELOAD(RELOAD)) u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .host_irq(host_irq), .dch_irq(dch_irq), .bch_irq(bch_irq), .per_rst(per_rst),
    .per_addr(per_addr), .bch_chan(bch_chan), .per_wdata(per_wdata),
    .dch_rd(dch_rd), .dch_wr(dch_wr), .dch_rdata(dch_rdata),
    .bch_rd(bch_rd), .bch_wr(bch_wr), .bch_rdata(bch_rdata),
    .led(led), .line_en(line_en)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_latch, m_r0, m_r1, m_wdata, m_rdata;
  logic [5:0] m_paddr;
  logic       m_chan, m_pend, m_irq, m_rv1, m_rv2;
  logic       m_drd, m_dwr, m_brd, m_bwr;
  int         m_cnt, m_tgt1, m_port1;

  function automatic int tgt_of(input logic [7:0] a);
    if (a >= 8'h80) return 2;
    if (a < 8'h40)  return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_read(input int port, input int tgt);
    case (port)
      2: return m_latch;
      3: return (tgt == 1) ? {2'b01, m_paddr} : (tgt == 2) ? {1'b1, m_chan, m_paddr} : 8'h00;
      4: return {m_r0[7], ~bch_irq, ~dch_irq, ~m_pend, 4'h0};
      5: return m_r1;
      6: return MID;
      7: return VID;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_latch = 0; m_r0 = 0; m_r1 = 0; m_wdata = 0; m_rdata = 0; m_paddr = 0;
      m_chan = 0; m_pend = 0; m_irq = 0; m_rv1 = 0; m_rv2 = 0;
      m_drd = 0; m_dwr = 0; m_brd = 0; m_bwr = 0; m_cnt = RELOAD; m_tgt1 = 0; m_port1 = 0;
    end else begin
      m_rv2 = m_rv1;
      if (m_rv1) m_rdata = exp_read(m_port1, m_tgt1);
      m_irq = m_r0[3] && (dch_irq || bch_irq || m_pend);
      if (m_r0[2]) begin m_cnt = RELOAD; m_pend = 0; end
      else if (!m_r0[1]) begin
        if (m_cnt == 0) begin m_cnt = RELOAD; m_pend = 1; end
        else m_cnt = m_cnt - 1;
      end
      m_drd = 0; m_dwr = 0; m_brd = 0; m_bwr = 0;
      m_rv1 = host_rd;
      if (host_wr) begin
        case (host_addr)
          3'd2: m_latch = host_wdata;
          3'd4: m_r0 = host_wdata;
          3'd5: m_r1 = host_wdata;
          3'd3: begin
            m_paddr = m_latch[5:0];
            m_chan = m_latch[7] & m_latch[6];
            m_wdata = host_wdata;
            m_dwr = (tgt_of(m_latch) == 1);
            m_bwr = (tgt_of(m_latch) == 2);
          end
          default: ;
        endcase
      end
      if (host_rd) begin
        m_port1 = int'(host_addr);
        m_tgt1 = tgt_of(m_latch);
        if (host_addr == 3'd3) begin
          m_paddr = m_latch[5:0];
          m_chan = m_latch[7] & m_latch[6];
          m_drd = (m_tgt1 == 1);
          m_brd = (m_tgt1 == 2);
        end
      end
    end
  end

  // compare every cycle, shortly after the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk("R4 dch_wr", dch_wr, m_dwr);
      chk("R4 bch_wr", bch_wr, m_bwr);
      chk("R5 dch_rd", dch_rd, m_drd);
      chk("R5 bch_rd", bch_rd, m_brd);
      chk("R3 per_addr/R2", per_addr, m_paddr);
      chk("R3 bch_chan", bch_chan, m_chan);
      chk("R4 per_wdata", per_wdata, m_wdata);
      chk("R7 per_rst", per_rst, m_r0[0]);
      chk("R9 host_irq", host_irq, m_irq);
      chk("R10 led", led, {m_r1[5], m_r1[4]});
      chk("R10 line_en", line_en, m_r1[7] & m_r1[6]);
      chk("R5 host_rvalid", host_rvalid, m_rv2);
      if (m_rv2) begin
        case (m_port1)
          2: chk("R2 latch readback", host_rdata, m_rdata);
          3: chk("R5 data read", host_rdata, m_rdata);
          4: chk("R6/R8 status read", host_rdata, m_rdata);
          5: chk("R10 ctl1 readback", host_rdata, m_rdata);
          default: chk("R11 id/unused read", host_rdata, m_rdata);
        endcase
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic hwr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk); host_addr = p; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] p);
    @(negedge clk); host_addr = p; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 strobes", {dch_rd, dch_wr, bch_rd, bch_wr}, 4'h0);
    chk("R1 per_rst", per_rst, 1'b0);
    chk("R1 host_irq", host_irq, 1'b0);
    chk("R1 led/line", {led, line_en}, 3'b000);
    chk("R1 rvalid/rdata", {host_rvalid, host_rdata}, 9'h000);
    // park the timer so it stays quiet
    hwr(3'd4, 8'h04);
    // R11: identification and unused ports, writes ignored
    hrd(3'd6); hrd(3'd7); hrd(3'd0); hrd(3'd1);
    hwr(3'd6, 8'hAA); hwr(3'd7, 8'h55); hwr(3'd0, 8'hFF); hwr(3'd1, 8'hFF);
    hrd(3'd6); hrd(3'd7); hrd(3'd0); hrd(3'd1);
    // R6 test bit presence check
    hwr(3'd4, 8'h84); hrd(3'd4);
    // R7 reset sequence
    hwr(3'd4, 8'h04); idle(3);
    hwr(3'd4, 8'h05); idle(10);
    hwr(3'd4, 8'h04); idle(3);
    // R10 aux control
    hwr(3'd5, 8'hF0); hrd(3'd5);
    hwr(3'd5, 8'h70); hrd(3'd5);
    hwr(3'd5, 8'h90); hrd(3'd5);
    hwr(3'd5, 8'h00); hrd(3'd5);
    // R2..R5 windows, repeated accesses without increment
    foreach (addrs[i]) begin
      hwr(3'd2, addrs[i]); hrd(3'd2);
      hwr(3'd3, 8'h5A ^ addrs[i]); hwr(3'd3, 8'hC3);
      hrd(3'd3); hrd(3'd3);
    end
    // back-to-back data reads
    hwr(3'd2, 8'hA7);
    @(negedge clk); host_addr = 3'd3; host_rd = 1'b1;
    @(negedge clk); @(negedge clk); host_rd = 1'b0;
    idle(3);
    // R9 interrupt merge with enable
    dch_irq = 1'b1; idle(3); hrd(3'd4);
    hwr(3'd4, 8'h0C); idle(3); hrd(3'd4);
    bch_irq = 1'b1; idle(2); dch_irq = 1'b0; idle(2); hrd(3'd4);
    bch_irq = 1'b0; idle(3); hrd(3'd4);
    // R8 timer run, freeze, clear
    hwr(3'd4, 8'h08); idle(250); hrd(3'd4);
    hwr(3'd4, 8'h0C); idle(5); hrd(3'd4);
    hwr(3'd4, 8'h08); idle(50);
    hwr(3'd4, 8'h0A); idle(120); hrd(3'd4);
    hwr(3'd4, 8'h08); idle(120); hrd(3'd4);
    hwr(3'd4, 8'h00); idle(5);
    hwr(3'd4, 8'h04); idle(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [7:0] addrs [8] = '{8'h00, 8'h23, 8'h45, 8'h80, 8'hA7, 8'hC3, 8'hFF, 8'h3F};
endmodule